// File: doc/BRIEF.md
# Word ALU with Overflow Register Update

This block is a purely combinational arithmetic and logic unit for a 16-bit word machine. It takes a 4-bit basic opcode and two operand words, `a` and `b`. It returns a result word and a condition flag. For the arithmetic and shift operations it also returns a replacement value for the machine's overflow register, together with a write enable. The surrounding core fetches the operands, writes back the result and overflow word, and uses the condition flag to decide whether the next instruction is skipped.

The overflow word carries a different value for each operation:
- the carry out of an add;
- an all-ones mask on a subtract borrow;
- the upper half of a product;
- the fractional part of a quotient;
- the bits pushed out by a shift.

Division and remainder by zero return defined zeros rather than undefined values. All widths are parameters. A parameter selects between a staged logarithmic shifter and a plain operator shifter.

Top module: `word_alu`

## Requirements
- R1: The opcode encoding is 0x1 move, 0x2 add, 0x3 subtract, 0x4 multiply, 0x5 divide, 0x6 remainder, 0x7 shift left, 0x8 shift right, 0x9 AND, 0xA OR, 0xB XOR, 0xC equal test, 0xD not-equal test, 0xE greater test, 0xF bit test. The move operation returns `b` as the result and does not write the overflow word.
- R2: Add returns (a+b) mod 2^16 and writes the overflow word with 0x0001 when the sum carries out of 16 bits, otherwise with 0x0000.
- R3: Subtract returns (a-b) mod 2^16 and writes the overflow word with 0xFFFF when b > a, otherwise with 0x0000.
- R4: Multiply returns the low 16 bits of a*b and writes the overflow word with the high 16 bits.
- R5: Divide returns floor(a/b) and writes the overflow word with floor(a*65536/b) mod 65536. When b is 0, both the result and the overflow word are 0, and the overflow word is still written.
- R6: Remainder returns a mod b, or 0 when b is 0, and never writes the overflow word.
- R7: Shift left with b < 32 returns (a<<b) mod 65536 and writes the overflow word with floor((a<<b)/65536) mod 65536.
- R8: Shift right with b < 32 returns floor(a/2^b) and writes the overflow word with floor(a*65536/2^b) mod 65536.
- R9: A shift amount b of 32 or more, in either direction, gives 0 in both the result and the overflow word, and the overflow word is still written.
- R10: AND, OR and XOR return the bitwise combination of a and b and never write the overflow word.
- R11: The condition flag is 1 for the equal test when a==b, for the not-equal test when a!=b, for the greater test when a>b unsigned, and for the bit test when (a&b)!=0. The four tests return `a` as the result and never write the overflow word.
- R12: The condition flag is 0 for every opcode below 0xC. Opcode 0x0 returns result 0, overflow word 0 and no overflow write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Basic opcode |
| a | input | 16 (W) | First operand word |
| b | input | 16 (W) | Second operand word |
| result | output | 16 (W) | Result word |
| ovf_out | output | 16 (W) | New overflow register value |
| ovf_we | output | 1 | Overflow register write enable |
| cond | output | 1 | Test outcome for opcodes 0xC to 0xF |

## Verification
There are no registers between the ports, so every output is due in the same cycle the operands are applied. No cycle of latency is counted for any operation, including divide and the shifts. The bench changes `op`, `a` and `b` on the falling edge of the clock and reads all four outputs 2 ns later, well before the next rising edge. Expected values are computed with 64-bit integer arithmetic for every opcode over a grid of operand pairs. The grid covers zero divisors, carry and borrow corners, and shift amounts on both sides of 16 and 32.

// File: rtl/word_alu_pkg.sv
package word_alu_pkg;
   typedef enum logic [3:0] {
      OP_EXT  = 4'h0,
      OP_MOVE = 4'h1,
      OP_ADD  = 4'h2,
      OP_SUB  = 4'h3,
      OP_MUL  = 4'h4,
      OP_DIV  = 4'h5,
      OP_REM  = 4'h6,
      OP_SHL  = 4'h7,
      OP_SHR  = 4'h8,
      OP_AND  = 4'h9,
      OP_OR   = 4'hA,
      OP_XOR  = 4'hB,
      OP_TEQ  = 4'hC,
      OP_TNE  = 4'hD,
      OP_TGT  = 4'hE,
      OP_TBIT = 4'hF
   } alu_op_e;

   localparam int OP_BITS = 4;
endpackage

// File: rtl/word_alu_addsub.sv
module word_alu_addsub #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] sum_ovf_o,
   output logic [W-1:0] diff_o,
   output logic [W-1:0] diff_ovf_o
);
   logic [W:0] wide_sum;
   logic       borrow;

   assign wide_sum   = {1'b0, a} + {1'b0, b};
   assign sum_o      = wide_sum[W-1:0];
   assign sum_ovf_o  = {{(W-1){1'b0}}, wide_sum[W]};
   assign borrow     = (b > a);
   assign diff_o     = a - b;
   assign diff_ovf_o = {W{borrow}};
endmodule

// File: rtl/word_alu_muldiv.sv
module word_alu_muldiv #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] prod_lo_o,
   output logic [W-1:0] prod_hi_o,
   output logic [W-1:0] quot_o,
   output logic [W-1:0] frac_o,
   output logic [W-1:0] rem_o
);
   localparam int DW = 2 * W;

   logic [DW-1:0] product;
   logic          div_zero;
   logic [W-1:0]  safe_b;
   logic [DW-1:0] frac_wide;
   logic [W-1:0]  raw_quot;
   logic [W-1:0]  raw_rem;

   assign product   = {{W{1'b0}}, a} * {{W{1'b0}}, b};
   assign prod_lo_o = product[W-1:0];
   assign prod_hi_o = product[DW-1:W];

   // A zero divisor is replaced before dividing; the outputs are then forced to zero.
   assign div_zero  = (b == '0);
   assign safe_b    = div_zero ? {{(W-1){1'b0}}, 1'b1} : b;
   assign raw_quot  = a / safe_b;
   assign raw_rem   = a % safe_b;
   assign frac_wide = {a, {W{1'b0}}} / {{W{1'b0}}, safe_b};

   assign quot_o = div_zero ? '0 : raw_quot;
   assign frac_o = div_zero ? '0 : frac_wide[W-1:0];
   assign rem_o  = div_zero ? '0 : raw_rem;
endmodule

// File: rtl/word_alu_shift.sv
module word_alu_shift #(
   parameter int W      = 16,
   parameter bit LEFT   = 1'b1,
   parameter bit BARREL = 1'b1
) (
   input  logic [W-1:0] val,
   input  logic [W-1:0] amt,
   output logic [W-1:0] main_o,
   output logic [W-1:0] spill_o
);
   localparam int DW = 2 * W;
   localparam int LG = $clog2(DW);

   logic [DW-1:0] start;
   logic [DW-1:0] shifted;
   logic [DW-1:0] fin;
   logic [LG-1:0] sa;
   logic          too_far;

   // Left: value sits in the low half; right: value sits in the high half.
   assign start   = LEFT ? {{W{1'b0}}, val} : {val, {W{1'b0}}};
   assign too_far = (amt >= W'(DW));
   assign sa      = amt[LG-1:0];

   generate
      if (BARREL) begin : g_barrel
         logic [DW-1:0] stg [LG+1];
         assign stg[0] = start;
         for (genvar k = 0; k < LG; k++) begin : g_stage
            if (LEFT) begin : g_l
               assign stg[k+1] = sa[k] ? (stg[k] << (1 << k)) : stg[k];
            end else begin : g_r
               assign stg[k+1] = sa[k] ? (stg[k] >> (1 << k)) : stg[k];
            end
         end
         assign shifted = stg[LG];
      end else begin : g_operator
         if (LEFT) begin : g_l
            assign shifted = start << sa;
         end else begin : g_r
            assign shifted = start >> sa;
         end
      end
   endgenerate

   assign fin     = too_far ? '0 : shifted;
   assign main_o  = LEFT ? fin[W-1:0] : fin[DW-1:W];
   assign spill_o = LEFT ? fin[DW-1:W] : fin[W-1:0];
endmodule

// File: rtl/word_alu_test.sv
module word_alu_test #(
   parameter int W = 16
) (
   input  logic [1:0]   sel,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         hit_o
);
   always_comb begin
      unique case (sel)
         2'd0:    hit_o = (a == b);
         2'd1:    hit_o = (a != b);
         2'd2:    hit_o = (a > b);
         default: hit_o = ((a & b) != '0);
      endcase
   end
endmodule

// File: rtl/word_alu.sv
module word_alu
   import word_alu_pkg::*;
#(
   parameter int W      = 16,
   parameter bit BARREL = 1'b1
) (
   input  logic [OP_BITS-1:0] op,
   input  logic [W-1:0]       a,
   input  logic [W-1:0]       b,
   output logic [W-1:0]       result,
   output logic [W-1:0]       ovf_out,
   output logic               ovf_we,
   output logic               cond
);
   generate
      if (W < 4) begin : g_bad_width
         $error("word_alu: W must be at least 4");
      end
   endgenerate

   logic [W-1:0] sum_w, sum_ovf, diff_w, diff_ovf;
   logic [W-1:0] prod_lo, prod_hi, quot_w, frac_w, rem_w;
   logic [W-1:0] shl_w, shl_ovf, shr_w, shr_ovf;
   logic         test_hit;
   alu_op_e      opc;

   assign opc = alu_op_e'(op);

   word_alu_addsub #(.W(W)) u_addsub (
      .a(a), .b(b),
      .sum_o(sum_w), .sum_ovf_o(sum_ovf),
      .diff_o(diff_w), .diff_ovf_o(diff_ovf)
   );

   word_alu_muldiv #(.W(W)) u_muldiv (
      .a(a), .b(b),
      .prod_lo_o(prod_lo), .prod_hi_o(prod_hi),
      .quot_o(quot_w), .frac_o(frac_w), .rem_o(rem_w)
   );

   word_alu_shift #(.W(W), .LEFT(1'b1), .BARREL(BARREL)) u_shl (
      .val(a), .amt(b), .main_o(shl_w), .spill_o(shl_ovf)
   );

   word_alu_shift #(.W(W), .LEFT(1'b0), .BARREL(BARREL)) u_shr (
      .val(a), .amt(b), .main_o(shr_w), .spill_o(shr_ovf)
   );

   word_alu_test #(.W(W)) u_test (
      .sel(op[1:0]), .a(a), .b(b), .hit_o(test_hit)
   );

   always_comb begin
      result  = '0;
      ovf_out = '0;
      ovf_we  = 1'b0;
      cond    = 1'b0;
      unique case (opc)
         OP_EXT:  result = '0;
         OP_MOVE: result = b;
         OP_ADD:  begin result = sum_w;   ovf_out = sum_ovf;  ovf_we = 1'b1; end
         OP_SUB:  begin result = diff_w;  ovf_out = diff_ovf; ovf_we = 1'b1; end
         OP_MUL:  begin result = prod_lo; ovf_out = prod_hi;  ovf_we = 1'b1; end
         OP_DIV:  begin result = quot_w;  ovf_out = frac_w;   ovf_we = 1'b1; end
         OP_REM:  result = rem_w;
         OP_SHL:  begin result = shl_w;   ovf_out = shl_ovf;  ovf_we = 1'b1; end
         OP_SHR:  begin result = shr_w;   ovf_out = shr_ovf;  ovf_we = 1'b1; end
         OP_AND:  result = a & b;
         OP_OR:   result = a | b;
         OP_XOR:  result = a ^ b;
         default: begin result = a; cond = test_hit; end
      endcase
   end
endmodule

// File: rtl/word_alu_chk.sv
module word_alu_chk #(
   parameter int W = 16
) (
   input logic [3:0]   op,
   input logic [W-1:0] a,
   input logic [W-1:0] b,
   input logic [W-1:0] result,
   input logic [W-1:0] ovf_out,
   input logic         ovf_we,
   input logic         cond
);
   always_comb begin
      AST_ADD_CARRY_BIT: assert (!(op == 4'h2) || (ovf_out[W-1:1] == '0)); // R2
      AST_SUB_MASK: assert (!(op == 4'h3) || (ovf_out == '0) || (ovf_out == {W{1'b1}})); // R3
      AST_DIV_BY_ZERO: assert (!(op == 4'h5 && b == '0) || (result == '0 && ovf_out == '0 && ovf_we)); // R5
      AST_REM_BOUND: assert (!(op == 4'h6 && b != '0) || (result < b)); // R6
      AST_SHIFT_WIDE: assert (!((op == 4'h7 || op == 4'h8) && b >= W'(2*W)) || (result == '0 && ovf_out == '0)); // R9
      AST_NO_OVF_WRITE: assert (!(op == 4'h0 || op == 4'h1 || op == 4'h6 || op >= 4'h9) || !ovf_we); // R10
      AST_COND_TESTS_ONLY: assert (!cond || (op >= 4'hC)); // R12
      AST_TEST_PASSES_A: assert (!(op >= 4'hC) || (result == a)); // R11
   end
endmodule

bind word_alu word_alu_chk #(.W(W)) u_chk (
   .op(op), .a(a), .b(b), .result(result),
   .ovf_out(ovf_out), .ovf_we(ovf_we), .cond(cond)
);

// File: tb/word_alu_bench.sv
`timescale 1ns/1ps
module word_alu_bench;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [3:0]   op = 4'h0;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic [W-1:0] result, ovf_out;
   logic         ovf_we, cond;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   word_alu #(.W(W), .BARREL(1'b1)) u_word_alu (
      .op(op), .a(a), .b(b), .result(result),
      .ovf_out(ovf_out), .ovf_we(ovf_we), .cond(cond)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog (all requirements): actual cycles=%0d expected completion", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   function automatic string tag_of(input int o);
      case (o)
         0: return "R12";
         1: return "R1";
         2: return "R2";
         3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         7: return "R7";
         8: return "R8";
         9, 10, 11: return "R10";
         default: return "R11";
      endcase
   endfunction

   function automatic logic [15:0] aval(input int i);
      case (i)
         0: return 16'h0000;  1: return 16'h0001;
         2: return 16'h0002;  3: return 16'h7FFF;
         4: return 16'h8000;  5: return 16'hFFFE;
         6: return 16'hFFFF;  7: return 16'h00FF;
         default: return 16'(i * 40503);
      endcase
   endfunction

   function automatic logic [15:0] bval(input int j);
      if (j < 8) return aval(j);
      else if (j < 24) return 16'((j - 8) * 3); // 0..45: shift amounts around 16 and 32
      else return 16'(j * 26959);
   endfunction

   task automatic check(input string tag, input string what,
                        input longint unsigned act, input longint unsigned exp);
      checks = checks + 1;
      if (act != exp) begin
         errors = errors + 1;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h (op=%0h a=%0h b=%0h)",
                  tag, what, act, exp, op, a, b);
      end
   endtask

   task automatic run_vec(input int o, input logic [15:0] va, input logic [15:0] vb);
      longint unsigned A, B, er, eo, t;
      bit ew, ec;
      A = va; B = vb; er = 0; eo = 0; ew = 0; ec = 0;
      case (o)
         1: er = B;                                          // R1
         2: begin t = A + B; er = t & 16'hFFFF; eo = (t >> 16) != 0 ? 1 : 0; ew = 1; end // R2
         3: begin er = (A - B) & 16'hFFFF; eo = (A < B) ? 16'hFFFF : 0; ew = 1; end     // R3
         4: begin t = A * B; er = t & 16'hFFFF; eo = (t >> 16) & 16'hFFFF; ew = 1; end  // R4
         5: begin ew = 1; if (B != 0) begin er = A / B; eo = ((A << 16) / B) & 16'hFFFF; end end // R5
         6: er = (B == 0) ? 0 : A % B;                       // R6
         7: begin ew = 1; if (B < 32) begin t = A << B; er = t & 16'hFFFF; eo = (t >> 16) & 16'hFFFF; end end // R7 R9
         8: begin ew = 1; if (B < 32) begin er = A >> B; eo = ((A << 16) >> B) & 16'hFFFF; end end // R8 R9
         9: er = A & B;                                      // R10
         10: er = A | B;
         11: er = A ^ B;
         12: begin er = A; ec = (A == B); end                // R11
         13: begin er = A; ec = (A != B); end
         14: begin er = A; ec = (A > B); end
         15: begin er = A; ec = ((A & B) != 0); end
         default: ;                                          // R12: opcode 0
      endcase
      @(negedge clk);
      op = 4'(o); a = va; b = vb;
      #2;
      check(tag_of(o), "result", longint'(result), er);
      check(tag_of(o), "ovf_we", longint'(ovf_we), longint'(ew));
      if (ew) check(tag_of(o), "ovf_out", longint'(ovf_out), eo);
      check((o < 12) ? "R12" : "R11", "cond", longint'(cond), longint'(ec));
      if ((o == 7 || o == 8) && B >= 32)
         check("R9", "wide shift zero", longint'(result | ovf_out), 0);
   endtask

   initial begin
      // Reset state: all-zero inputs give all-zero outputs (R12).
      repeat (2) @(negedge clk);
      #2;
      check("R12", "reset result", longint'(result), 0);
      check("R12", "reset ovf_we", longint'(ovf_we), 0);
      check("R12", "reset cond", longint'(cond), 0);
      rst = 1'b0;
      for (int o = 0; o < 16; o++)
         for (int i = 0; i < 48; i++)
            for (int j = 0; j < 48; j++)
               run_vec(o, aval(i), bval(j));
      // Explicit corners: R2 carry, R3 borrow, R5 zero divisor, R9 amount 32.
      run_vec(2, 16'hFFFF, 16'h0001);
      run_vec(3, 16'h0000, 16'h0001);
      run_vec(5, 16'h1234, 16'h0000);
      run_vec(7, 16'hFFFF, 16'd32);
      run_vec(8, 16'hFFFF, 16'd31);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule